// File: doc/BRIEF.md
# Single-Port SDRAM Controller with Power-Up Sequencer

This block sits between a simple host bus and one 32-bit SDRAM. It handles single-beat reads and writes. Each access opens the row, issues the column command with auto-precharge, and waits out the recovery time, so no bank is ever left open between accesses. A free-running timer raises a refresh request at a fixed interval. The controller issues AUTO REFRESH whenever a request is pending and the controller is idle, whether or not the host is waiting.

A small control register sets the device timing. Five one-bit selects each choose between a short and a long cycle count: CAS latency, row-to-column delay, write recovery, precharge time and refresh-to-active time. Two action bits are set by the host. The init bit starts a PRECHARGE ALL and stays set until that command has completed. The mode bit turns the next host access into a LOAD MODE command, and the mode word for that command comes from the access address.

Top module: `sdram_init_ctrl`

## Requirements
- R1: After reset the command pins {cs_n,ras_n,cas_n,we_n} show NOP (0111), host_ack is low and the control register reads 0. The other encodings are ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001 and LOAD MODE 0000.
- R2: The control register bits are [0] CAS latency 3, [1] long RAS-to-CAS, [2] long write recovery, [3] long precharge, [4] long refresh-to-active, [5] mode-load armed and [6] init busy. Bits 4..0 read back exactly as written.
- R3: Writing 1 to bit 6 issues PRECHARGE with sd_a[10]=1. Bit 6 reads 1 in the PRECHARGE cycle P and reads 0 from cycle P+trp onwards, where trp is 1 (bit 3 = 0) or 2 (bit 3 = 1).
- R4: A host access issues ACTIVE with sd_a = byte address bits [23:12] (row) and sd_ba = bits [11:10]. Exactly trcd cycles later (1 or 2, from bit 1) it issues READ or WRITE with sd_a[7:0] = bits [9:2] (column) and sd_a[10]=1.
- R5: For a read, host_ack is high for one cycle, exactly CL cycles after READ (CL 2 or 3, from bit 0). In that cycle host_rdata equals the data last written to that address.
- R6: For a write, host_ack is high in the WRITE cycle. In that cycle sd_dq_oe=1, sd_dq_out equals host_wdata and sd_dqm equals the inverted host_be.
- R7: Let twr be 1 or 2 (bit 2). The earliest next command comes CL+trp+1 cycles after READ, twr+trp+1 cycles after WRITE, trp+1 cycles after PRECHARGE and 3 cycles after LOAD MODE. If work is pending, the next command comes exactly then.
- R8: With no host traffic, AUTO REFRESH commands appear exactly REF_INTERVAL (624) cycles apart. After AUTO REFRESH the next command comes no earlier than trc+1 cycles later (trc 3 or 4, from bit 4), and exactly then if work is pending.
- R9: A pending refresh wins over a waiting host access. Under back-to-back host traffic, refreshes still appear within 16 cycles of the nominal interval.
- R10: While bit 5 is set, the next access issues LOAD MODE and no ACTIVE. In that command {sd_ba,sd_a} equals the byte address shifted right by 2 (0x88 gives 0x22, 0xC8 gives 0x32). host_ack is high in that cycle and bit 5 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until host_ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W (24) | Byte address |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte enables, active high |
| host_ack | output | 1 | One-cycle transfer acknowledge |
| host_rdata | output | 32 | Read data, valid while host_ack is high on a read |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control register write value |
| ctl_rdata | output | 7 | Control register contents |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BA_W (2) | Bank address |
| sd_a | output | A_W (13) | Row, column or mode address |
| sd_dqm | output | 4 | Byte masks |
| sd_dq_out | output | 32 | Data toward the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 32 | Data from the device |

## Verification
Every result is timed against the command that caused it. The column command comes trcd cycles after ACTIVE. A read acknowledge comes CL cycles after READ, while a write or mode-load acknowledge comes in the same cycle as its command. The init bit clears trp cycles after PRECHARGE ALL. A monitor samples the pins at the falling edge and timestamps each command. It then checks each spacing exactly against the selects captured when the command was issued, so every cycle count is measured from the command that set it. Spacing between commands is checked for exact equality when the bench keeps a request waiting, and only as a lower bound when it does not.

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl #(
  parameter int COL_W = 8,
  parameter int ROW_W = 12,
  parameter int BA_W = 2,
  parameter int A_W = 13,
  parameter int REF_INTERVAL = 624,
  localparam int ADDR_W = 2 + COL_W + BA_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  input  logic [3:0]        host_be,
  output logic              host_ack,
  output logic [31:0]       host_rdata,
  input  logic              ctl_we,
  input  logic [6:0]        ctl_wdata,
  output logic [6:0]        ctl_rdata,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [A_W-1:0]    sd_a,
  output logic [3:0]        sd_dqm,
  output logic [31:0]       sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [31:0]       sd_dq_in
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int RC_W = $clog2(REF_INTERVAL);
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

  typedef enum logic [1:0] {S_IDLE, S_RCD, S_CAS, S_WAIT} st_t;

  st_t             st;
  logic [6:0]      ctl;
  logic [4:0]      tl;
  logic [2:0]      cnt;
  logic [3:0]      cmd;
  logic            init_run, ref_pend;
  logic [RC_W-1:0] rcnt;
  logic [A_W-1:0]  a_col;
  logic            unused_lsb;

  wire [WORD_W-1:0] wa   = host_addr[ADDR_W-1:2];
  wire [COL_W-1:0]  col  = wa[COL_W-1:0];
  wire [BA_W-1:0]   bank = wa[COL_W +: BA_W];
  wire [ROW_W-1:0]  row  = wa[COL_W+BA_W +: ROW_W];

  function automatic logic [2:0] pick(input logic b, input logic [2:0] lo, input logic [2:0] hi);
    return b ? hi : lo;
  endfunction

  wire [4:0] tsrc  = (st == S_IDLE) ? ctl[4:0] : tl;
  wire [2:0] n_cl  = pick(tsrc[0], 3'd2, 3'd3);
  wire [2:0] n_rcd = pick(tsrc[1], 3'd1, 3'd2);
  wire [2:0] n_wr  = pick(tsrc[2], 3'd1, 3'd2);
  wire [2:0] n_rp  = pick(tsrc[3], 3'd1, 3'd2);
  wire [2:0] n_rc  = pick(tsrc[4], 3'd3, 3'd4);

  always_comb begin
    a_col = '0;
    a_col[COL_W-1:0] = col;
    a_col[10] = 1'b1;
  end

  assign unused_lsb = ^host_addr[1:0];
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign host_rdata = sd_dq_in;
  assign ctl_rdata = ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ctl <= '0; tl <= '0; cnt <= '0; cmd <= C_NOP;
      init_run <= 1'b0; ref_pend <= 1'b0; rcnt <= RC_W'(REF_INTERVAL - 1);
      host_ack <= 1'b0; sd_ba <= '0; sd_a <= '0; sd_dqm <= '0;
      sd_dq_out <= '0; sd_dq_oe <= 1'b0;
    end else begin
      cmd <= C_NOP;
      host_ack <= 1'b0;
      sd_dq_oe <= 1'b0;
      case (st)
        S_IDLE: begin
          tl <= ctl[4:0];
          if (ctl[6] && !init_run) begin
            cmd <= C_PRE; sd_a <= A_W'(1 << 10); init_run <= 1'b1;
            cnt <= n_rp - 3'd1; st <= S_WAIT;
          end else if (ref_pend) begin
            cmd <= C_REF; ref_pend <= 1'b0; cnt <= n_rc - 3'd1; st <= S_WAIT;
          end else if (host_req && ctl[5]) begin
            cmd <= C_LMR; {sd_ba, sd_a} <= wa[A_W+BA_W-1:0]; host_ack <= 1'b1;
            ctl[5] <= 1'b0; cnt <= 3'd1; st <= S_WAIT;
          end else if (host_req) begin
            cmd <= C_ACT; sd_ba <= bank; sd_a <= A_W'(row);
            cnt <= n_rcd - 3'd1; st <= S_RCD;
          end
        end
        S_RCD: begin
          if (cnt != 0) cnt <= cnt - 3'd1;
          else begin
            sd_ba <= bank; sd_a <= a_col;
            if (host_we) begin
              cmd <= C_WR; sd_dq_out <= host_wdata; sd_dq_oe <= 1'b1; sd_dqm <= ~host_be;
              host_ack <= 1'b1; cnt <= n_wr + n_rp - 3'd1; st <= S_WAIT;
            end else begin
              cmd <= C_RD; sd_dqm <= '0; cnt <= n_cl - 3'd1; st <= S_CAS;
            end
          end
        end
        S_CAS: begin
          if (cnt != 0) cnt <= cnt - 3'd1;
          else begin
            host_ack <= 1'b1; cnt <= n_rp - 3'd1; st <= S_WAIT;
          end
        end
        default: begin
          if (cnt != 0) cnt <= cnt - 3'd1;
          else begin
            st <= S_IDLE;
            if (init_run) begin
              init_run <= 1'b0; ctl[6] <= 1'b0;
            end
          end
        end
      endcase
      if (rcnt == 0) begin
        rcnt <= RC_W'(REF_INTERVAL - 1);
        ref_pend <= 1'b1;
      end else begin
        rcnt <= rcnt - 1'b1;
      end
      if (ctl_we) begin
        ctl[5:0] <= ctl_wdata[5:0];
        if (ctl_wdata[6]) ctl[6] <= 1'b1;
      end
    end
  end

  assert_pre_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> sd_a[10]);
  assert_col_after_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD || cmd == C_WR) |-> ($past(cmd) == C_ACT || $past(cmd, 2) == C_ACT));
  assert_ack_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> (cmd == C_WR || cmd == C_LMR || $past(cmd, 2) == C_RD || $past(cmd, 3) == C_RD));
  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);
  assert_gap_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_NOP && cmd != C_RD && cmd != C_WR) |-> $past(cmd) == C_NOP);
  assert_ref_due_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_REF) |-> $past(ref_pend));
  assert_lmr_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_LMR) |-> host_ack);
endmodule

// File: tb/sdram_init_ctrl_bench.sv
module sdram_init_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REF = 624;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100;
  localparam logic [3:0] PRE = 4'b0010, RFS = 4'b0001, LMR = 4'b0000;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0, host_ack;
  logic [23:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic [3:0] host_be = '0;
  logic ctl_we = 0;
  logic [6:0] ctl_wdata = '0, ctl_rdata;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [12:0] sd_a;
  logic [3:0] sd_dqm;
  logic [31:0] sd_dq_out, sd_dq_in = '0;

  sdram_init_ctrl u_sdram_init_ctrl (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int f_cl(input logic [4:0] c);  return c[0] ? 3 : 2; endfunction
  function automatic int f_rcd(input logic [4:0] c); return c[1] ? 2 : 1; endfunction
  function automatic int f_wr(input logic [4:0] c);  return c[2] ? 2 : 1; endfunction
  function automatic int f_rp(input logic [4:0] c);  return c[3] ? 2 : 1; endfunction
  function automatic int f_rc(input logic [4:0] c);  return c[4] ? 4 : 3; endfunction

  logic [31:0] dmem [int];
  logic [31:0] shadow [int];
  logic [12:0] row_q [4];
  logic [23:0] cur_addr = '0;
  logic [31:0] cur_wdata = '0;
  logic [3:0] cur_be = '0;
  bit chain = 0, idle_win = 0, stream_win = 0, have_prev = 0, last_ref_idle = 0, last_ref_str = 0;
  bit init_q = 0;
  logic [4:0] cfg_q = '0, acfg = '0, pcfg = '0, pre_cfg = '0;
  logic [3:0] ptype = NOP;
  bit pchain = 0;
  int t_prev = 0, t_act = 0, t_rd = 0, t_pre = 0, t_ref = 0, rd_due = -1;
  int n_act = 0, n_pre = 0, n_ref_idle = 0, n_ref_str = 0, n_lmr = 0;
  logic [31:0] rd_val = '0;

  function automatic int key_of(input logic [23:0] a);
    return int'(a[23:2]);
  endfunction

  always @(negedge clk) begin
    logic [3:0] c;
    int need, gap, k;
    logic [31:0] m;
    if (rst_n) begin
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (host_ack && c != WR && c != LMR) begin
        chk(cyc - t_rd == f_cl(acfg), "R5 read ack latency", cyc - t_rd, f_cl(acfg));
        k = key_of(cur_addr);
        chk(host_rdata == (shadow.exists(k) ? shadow[k] : 32'h0), "R5 read data",
            host_rdata, shadow.exists(k) ? shadow[k] : 32'h0);
      end
      if (c != NOP) begin
        if (have_prev && ptype != ACT) begin
          gap = cyc - t_prev;
          case (ptype)
            RD: need = f_cl(pcfg) + f_rp(pcfg) + 1;
            WR: need = f_wr(pcfg) + f_rp(pcfg) + 1;
            PRE: need = f_rp(pcfg) + 1;
            RFS: need = f_rc(pcfg) + 1;
            default: need = 3;
          endcase
          if (pchain) chk(gap == need, (ptype == RFS) ? "R8 refresh to next exact" : "R7 next command exact", gap, need);
          else chk(gap >= need, (ptype == RFS) ? "R8 refresh to next min" : "R7 next command min", gap, need);
        end
        case (c)
          ACT: begin
            t_act = cyc; acfg = cfg_q; n_act++;
            row_q[sd_ba] = sd_a;
            chk(sd_a == {1'b0, cur_addr[23:12]}, "R4 row", sd_a, cur_addr[23:12]);
            chk(sd_ba == cur_addr[11:10], "R4 bank", sd_ba, cur_addr[11:10]);
          end
          RD, WR: begin
            chk(cyc - t_act == f_rcd(acfg), "R4 act to column", cyc - t_act, f_rcd(acfg));
            chk(sd_a[10] && sd_a[7:0] == cur_addr[9:2], "R4 column", sd_a, {1'b1, 2'b0, cur_addr[9:2]});
            k = int'({row_q[sd_ba][11:0], sd_ba, sd_a[7:0]});
            if (c == RD) begin
              t_rd = cyc; rd_due = cyc + f_cl(acfg);
              rd_val = dmem.exists(k) ? dmem[k] : 32'h0;
            end else begin
              chk(host_ack, "R6 ack with write", host_ack, 1);
              chk(sd_dq_oe && sd_dq_out == cur_wdata, "R6 write data", sd_dq_out, cur_wdata);
              chk(sd_dqm == ~cur_be, "R6 byte mask", sd_dqm, ~cur_be);
              m = dmem.exists(k) ? dmem[k] : 32'h0;
              for (int b = 0; b < 4; b++) if (!sd_dqm[b]) m[8*b +: 8] = sd_dq_out[8*b +: 8];
              dmem[k] = m;
            end
          end
          PRE: begin
            t_pre = cyc; pre_cfg = cfg_q; n_pre++;
            chk(sd_a[10], "R3 precharge all A10", sd_a[10], 1);
            chk(ctl_rdata[6], "R3 init busy in precharge cycle", ctl_rdata[6], 1);
          end
          RFS: begin
            if (idle_win) begin
              n_ref_idle++;
              if (last_ref_idle) chk(cyc - t_ref == REF, "R8 idle refresh interval", cyc - t_ref, REF);
            end
            if (stream_win) begin
              n_ref_str++;
              if (last_ref_str) chk(cyc - t_ref >= REF - 16 && cyc - t_ref <= REF + 16,
                                    "R9 refresh under traffic", cyc - t_ref, REF);
            end
            last_ref_idle = idle_win; last_ref_str = stream_win; t_ref = cyc;
          end
          LMR: begin
            n_lmr++;
            chk({sd_ba, sd_a} == cur_addr[16:2], "R10 mode word", {sd_ba, sd_a}, cur_addr[16:2]);
            chk(host_ack, "R10 ack with mode load", host_ack, 1);
            chk(!ctl_rdata[5], "R10 arm bit cleared", ctl_rdata[5], 0);
          end
          default: chk(0, "R1 unknown command", c, NOP);
        endcase
        have_prev = 1; t_prev = cyc; ptype = c; pchain = chain;
        pcfg = (c == RD || c == WR) ? acfg : cfg_q;
      end
      if (init_q && !ctl_rdata[6])
        chk(cyc == t_pre + f_rp(pre_cfg), "R3 init bit clear cycle", cyc, t_pre + f_rp(pre_cfg));
      init_q = ctl_rdata[6];
      cfg_q = ctl_rdata[4:0];
      sd_dq_in = (cyc + 1 == rd_due) ? rd_val : (32'hA5A5_0000 ^ cyc);
    end
  end

  task automatic ctl_write(input logic [6:0] d);
    @(negedge clk); #1;
    ctl_we = 1; ctl_wdata = d;
    @(negedge clk); #1;
    ctl_we = 0;
  endtask

  task automatic access(input bit we, input logic [23:0] addr, input logic [31:0] d,
                        input logic [3:0] be, input bit more);
    int w = 0;
    logic [31:0] m;
    chain = more;
    host_we = we; host_addr = addr; host_wdata = d; host_be = be; host_req = 1;
    cur_addr = addr; cur_wdata = d; cur_be = be;
    do begin
      @(negedge clk);
      w++;
    end while (!host_ack && w < 100);
    #1;
    chk(w < 100, "R4 access completes", w, 20);
    if (we) begin
      m = shadow.exists(key_of(addr)) ? shadow[key_of(addr)] : 32'h0;
      for (int b = 0; b < 4; b++) if (be[b]) m[8*b +: 8] = d[8*b +: 8];
      shadow[key_of(addr)] = m;
    end
    if (!more) host_req = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int start, a0;
    logic [23:0] a1, a2;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == NOP, "R1 reset command", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, NOP);
    chk(!host_ack, "R1 reset ack", host_ack, 0);
    chk(ctl_rdata == 0, "R1 reset control", ctl_rdata, 0);

    ctl_write(7'b0010110);
    chk(ctl_rdata == 7'b0010110, "R2 readback", ctl_rdata, 7'b0010110);

    ctl_write(7'b1000000);
    repeat (8) @(negedge clk);
    #1;
    ctl_write(7'b1001000);
    repeat (8) @(negedge clk);
    #1;
    chk(n_pre == 2, "R3 precharge count", n_pre, 2);
    chk(!ctl_rdata[6], "R3 init done", ctl_rdata[6], 0);

    idle_win = 1;
    repeat (8 * REF + 50) @(negedge clk);
    #1;
    idle_win = 0;
    chk(n_ref_idle >= 8, "R8 refreshes while idle", n_ref_idle, 8);

    a0 = n_act;
    ctl_write(7'b0100000);
    access(0, 24'h000088, 0, 4'h0, 0);
    ctl_write(7'b0100001);
    access(0, 24'h0000C8, 0, 4'h0, 0);
    @(negedge clk); #1;
    chk(n_act == a0, "R10 no activate for mode load", n_act, a0);
    chk(n_lmr == 2, "R10 mode loads", n_lmr, 2);

    for (int cfg = 0; cfg < 32; cfg++) begin
      ctl_write(7'(cfg));
      chk(ctl_rdata[4:0] == 5'(cfg), "R2 timing readback", ctl_rdata[4:0], cfg);
      a1 = {12'(cfg * 37 + 1), 2'(cfg), 8'(cfg * 5), 2'b00};
      a2 = {12'(cfg * 11 + 900), 2'(cfg + 1), 8'(255 - cfg), 2'b00};
      access(1, a1, 32'h1000_0000 + cfg, 4'hF, 1);
      access(1, a2, 32'hBEEF_0000 ^ (cfg << 8), 4'hF, 1);
      access(1, a1, 32'hCC00_77AA + cfg, 4'(cfg | 1), 1);
      access(0, a1, 0, 4'h0, 1);
      access(0, a2, 0, 4'h0, 0);
    end

    ctl_write(7'b0001010);
    stream_win = 1;
    start = cyc;
    while (cyc < start + 3000) begin
      access(1, {12'(cyc), 2'(cyc), 8'(cyc), 2'b00}, cyc, 4'hF, 1);
      access(0, {12'(cyc - 1), 2'(cyc), 8'(cyc), 2'b00}, 0, 4'h0, 1);
    end
    access(0, 24'h001234, 0, 4'h0, 0);
    stream_win = 0;
    chk(n_ref_str >= 4, "R9 refreshes under traffic", n_ref_str, 4);

    repeat (10) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule